// File: doc/BRIEF.md
# Write-Through Cache with Store Queue

This block sits between a processor and a single-port word memory. It holds a small direct-mapped cache of single-word lines and a four-entry first-in first-out store queue. Loads that find a valid line with a matching tag return the cached word in the cycle they are accepted. Every store is placed in the queue. A store whose line is present also updates the cached word. A store whose line is absent leaves the cache untouched, so no line is allocated on a store.

The queue empties toward memory in the background, one entry for each cycle in which memory signals ready. The processor is therefore held only when it issues a store while the queue is full. A load miss is held until the queue is empty, so no older store can still be in flight. The block then reads the word from memory and fills the line. On the next cycle the load completes as a hit.

The processor keeps a request asserted until it sees stall low at a clock edge, and the request is accepted at that edge. Memory finishes a transfer in any cycle where it sees mem_req and mem_ready high together. Read data must be valid during that same cycle.

Top module: `wt_cache_top`

## Requirements
- R1: After reset every line is invalid, the store queue is empty, mem_req is low, and stall is low while no request is presented.
- R2: A load whose line is valid, with a stored tag equal to the upper address bits, is accepted with no stall and no memory read, and returns the cached word. This holds even while the queue is non-empty or memory is not ready.
- R3: Each accepted store reaches memory exactly once, with its address and data, in acceptance order. One entry is written per cycle with mem_req, mem_we and mem_ready high. A write that is not yet acknowledged holds its address and data stable.
- R4: A store to a present line updates the cached word, so a later load to that address hits and returns the new data.
- R5: A store to an absent line fills nothing, so a later load to that address misses and reads memory.
- R6: A store stalls only when the queue already holds 4 entries. With fewer entries it is accepted in the cycle it is presented.
- R7: A load miss raises stall and issues a memory read (mem_req high, mem_we low) only once the queue is empty. It fills the line with the word read and returns that word, which includes any data from stores issued earlier.
- R8: The line index is the low IDX_W bits of the word address and the tag is the remaining upper bits. Two addresses with the same index and different tags evict each other, so alternating loads between them all miss.
- R9: When a store is accepted in the same cycle as a queue entry is written to memory, the queue occupancy is unchanged. Back-to-back stores with memory always ready never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_stall | output | 1 | Request not accepted this cycle |
| rd_data | output | DATA_W | Load result, valid when a load is accepted |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write from the queue, 0 = line fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |

## Verification
Two things can happen in the same cycle: a new store can be pushed into the queue while the oldest entry is popped by a memory write. The bench provokes this with runs of consecutive stores while memory is always ready. It judges the result at the ports: no store may stall, and the writes seen at the memory must match the bench's own list of accepted stores, in order. A store hit and a queue drain can also coincide. The bench judges that case by a later load that must return the new word with no memory read. It also checks that memory, once drained, equals the bench's reference image.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} mem_op_e;

  // circular increment for a ring of the given depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic              v_q [LINES];
  logic [TAG_W-1:0]  t_q [LINES];
  logic [DATA_W-1:0] d_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
        t_q[g] <= '0;
        d_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q[g] <= 1'b1;
        t_q[g] <= wr_tag;
        d_q[g] <= wr_data;
      end
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_tag   = t_q[rd_idx];
  assign rd_data  = d_q[rd_idx];
endmodule

// File: rtl/wt_wbuf.sv
module wt_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 24,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wt_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wt_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_data;
  end

  assign head  = slot[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wt_cache_top.sv
module wt_cache_top #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_stall,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wt_pkg::*;

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(WB_DEPTH + 1);

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // named internal events
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              hit_evt;
  logic              load_miss;
  logic              store_acc;
  logic              fill_evt;
  logic              wb_pop;
  logic              wb_empty, wb_full;
  logic [CNT_W-1:0]  wb_count;
  logic [ENT_W-1:0]  wb_head;
  logic              line_wr;
  logic [DATA_W-1:0] line_wdata;
  mem_op_e           op;

  assign hit_evt   = req_valid && line_valid && (line_tag == tag_of(req_addr));
  assign load_miss = req_valid && !req_write && !hit_evt;
  assign store_acc = req_valid && req_write && !wb_full;
  assign req_stall = load_miss || (req_valid && req_write && wb_full);

  assign op        = wb_empty ? OP_RD : OP_WR;
  assign mem_req   = !wb_empty || load_miss;
  assign mem_we    = (op == OP_WR);
  assign mem_addr  = wb_empty ? req_addr : wb_head[ENT_W-1:DATA_W];
  assign mem_wdata = wb_head[DATA_W-1:0];
  assign wb_pop    = !wb_empty && mem_ready;
  assign fill_evt  = load_miss && wb_empty && mem_ready;

  assign line_wr    = fill_evt || (store_acc && hit_evt);
  assign line_wdata = fill_evt ? mem_rdata : req_wdata;
  assign rd_data    = line_data;

  wt_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (idx_of(req_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (line_wr),
    .wr_idx   (idx_of(req_addr)),
    .wr_tag   (tag_of(req_addr)),
    .wr_data  (line_wdata)
  );

  wt_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store_acc),
    .push_data ({req_addr, req_wdata}),
    .pop       (wb_pop),
    .head      (wb_head),
    .empty     (wb_empty),
    .full      (wb_full),
    .count     (wb_count)
  );
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wb_full,
  input logic              wb_empty,
  input logic [CNT_W-1:0]  wb_count,
  input logic              store_acc,
  input logic              wb_pop,
  input logic              hit_evt
);
  // R6
  store_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_stall) |-> wb_full);

  // R7
  read_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wb_empty);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ready) |=>
      (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  // R9
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_acc && wb_pop) |=> (wb_count == $past(wb_count)));

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CNT_W'(DEPTH));

  // R2
  load_hit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && hit_evt) |-> !req_stall);
endmodule

bind wt_cache_top wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_stall (req_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wb_full   (wb_full),
  .wb_empty  (wb_empty),
  .wb_count  (wb_count),
  .store_acc (store_acc),
  .wb_pop    (wb_pop),
  .hit_evt   (hit_evt)
);

// File: tb/sim_wt_cache_top.sv
`timescale 1ns/1ps
module sim_wt_cache_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_stall;
  logic [15:0] rd_data;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata;

  always #2 clk = ~clk;

  wt_cache_top u0 (.*);

  int checks = 0, fails = 0;
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [7:0]  exp_a [256];
  logic [15:0] exp_d [256];
  int exp_n = 0, wr_n = 0, rd_n = 0, cyc = 0;
  bit ready_hold = 1'b0, slow_mode = 1'b0;
  bit       m_valid [4];
  logic [5:0] m_tag [4];

  assign mem_rdata = mem[mem_addr];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_ready = !ready_hold && (slow_mode ? (cyc % 3 == 0) : 1'b1);
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        chk(wr_n < exp_n && mem_addr == exp_a[wr_n[7:0]] && mem_wdata == exp_d[wr_n[7:0]],
            "R3 write order", {8'h0, mem_addr, mem_wdata}, {8'h0, exp_a[wr_n[7:0]], exp_d[wr_n[7:0]]});
        mem[mem_addr] = mem_wdata;
        wr_n++;
      end else begin
        rd_n++;
      end
    end
  end

  task automatic acc(input bit w, input logic [7:0] a, input logic [15:0] d,
                     output logic [15:0] q, output bit stalled);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    stalled = 1'b0;
    forever begin
      #1;
      if (!req_stall) break;
      stalled = 1'b1;
      @(negedge clk);
    end
    q = rd_data;
    if (w) begin
      exp_a[exp_n[7:0]] = a; exp_d[exp_n[7:0]] = d; exp_n++;
      ref_mem[a] = d;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] a, input string rq);
    logic [15:0] q; bit st; bit hit; int r0;
    hit = m_valid[a[1:0]] && m_tag[a[1:0]] == a[7:2];
    r0 = rd_n;
    acc(1'b0, a, 16'h0, q, st);
    chk(q == ref_mem[a], rq, q, ref_mem[a]);
    chk((rd_n - r0) == (hit ? 0 : 1), rq, rd_n - r0, hit ? 0 : 1);
    chk(st == !hit, rq, st, !hit);
    m_valid[a[1:0]] = 1'b1; m_tag[a[1:0]] = a[7:2];
  endtask

  task automatic do_store(input logic [7:0] a, input logic [15:0] d, input bit may_stall, input string rq);
    logic [15:0] q; bit st;
    acc(1'b1, a, d, q, st);
    if (!may_stall) chk(!st, rq, st, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] q; bit st;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 37 + 5); ref_mem[i] = mem[i];
    end
    for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_stall == 1'b0, "R1 stall", req_stall, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);

    do_load(8'h10, "R7 first miss");
    do_load(8'h10, "R2 hit");
    do_store(8'h10, 16'hBEEF, 1'b0, "R4 store hit");
    do_load(8'h10, "R4 updated hit");
    do_store(8'h21, 16'h1234, 1'b0, "R5 store miss");
    do_load(8'h21, "R5 no allocate");
    // R8 conflict ping-pong
    do_load(8'h03, "R8 conflict");
    do_load(8'h07, "R8 conflict");
    do_load(8'h03, "R8 conflict");
    do_load(8'h07, "R8 conflict");

    // R6 full queue
    ready_hold = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) do_store(8'(8'h40 + i), 16'(16'hA000 + i), 1'b0, "R6 not full");
    do_load(8'h10, "R2 hit with full queue");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h44; req_wdata = 16'hA004;
    for (int k = 0; k < 3; k++) begin
      #1 chk(req_stall == 1'b1, "R6 full stall", req_stall, 1);
      @(negedge clk);
    end
    ready_hold = 1'b0;
    acc(1'b1, 8'h44, 16'hA004, q, st);

    // R9 push and pop together
    for (int i = 0; i < 8; i++) do_store(8'(8'h80 + i), 16'(16'hC000 + i * 3), 1'b0, "R9 no stall");
    do_load(8'h83, "R7 after burst");

    // sweep with slow memory
    slow_mode = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i % 4 == 3) do_store(8'(i), 16'(i * 11 + 1), 1'b1, "R3 sweep store");
      else do_load(8'(i), "R8 sweep load");
    end
    for (int i = 0; i < 64; i++) do_load(8'(i), "R7 sweep reload");

    slow_mode = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(wr_n == exp_n, "R3 all written", wr_n, exp_n);
    chk(mem_req == 1'b0, "R3 idle", mem_req, 0);
    for (int i = 0; i < 256; i++)
      if (mem[i] != ref_mem[i]) chk(1'b0, "R3 memory image", mem[i], ref_mem[i]);
    chk(1'b1, "R3 image scanned", 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule